// File: doc/BRIEF.md
# Parallel Turbo Half-Iteration Address Scheduler

This block drives the address side of a parallel turbo decoder with `LANES` soft-in soft-out lanes working on one code block of run-time size K. The block is cut into `LANES` contiguous slices of K/`LANES` positions; lane p owns the slice starting at p·K/`LANES`. In every cycle of a half iteration each lane gets one read address and one write address, each split into a memory module index and an offset within that module.

Reads always walk the slice in natural order. All permutation is placed on the write side: during the first half of an iteration the write address is the interleaved position, and during the second half it is the deinterleaved position. Both the forward and the inverse permutation come from two loadable tables, so no interleaver algorithm of any standard is built in, and one datapath serves both modes in turn. A half iteration closes only when the downstream write path reports that it is empty. After the configured number of full iterations a one-cycle done pulse is raised.

Top module: `turbo_half_sched`

## Requirements
- R1: After reset the block is idle: `busy`, `addr_valid`, `done`, `err_cfg` and `err_rd` are all 0.
- R2: After an accepted `start`, `addr_valid` is high for K/`LANES` consecutive cycles per half iteration, and in step s (counting from 0) lane p reads position p·K/`LANES` + s.
- R3: Every position is split the same way on both read and write outputs: module index = position mod `LANES` (its low log2(`LANES`) bits), offset = position div `LANES` (the remaining high bits). Lane p uses the field slice p of each output bus.
- R4: In the first half (`half` = 0) each lane's write address is the forward table entry at its read position.
- R5: In the second half (`half` = 1) each lane's write address is the inverse table entry at its read position.
- R6: After the last step of a half, `addr_valid` stays low while `busy` stays high for as long as `wr_empty` is 0; the next half (or the finish) follows in the cycle after `wr_empty` is seen high.
- R7: Exactly `cfg_iters` full iterations run, `iter` reporting the current one from 0; after the last one `busy` falls and `done` is high for exactly one cycle.
- R8: `err_rd` is set if, in any valid cycle, two lanes read from the same module; it holds until the next accepted `start`, which clears it.
- R9: A `start` with K = 0, K > `DEPTH`, K not a multiple of `LANES`, or `cfg_iters` = 0 is rejected: the block stays idle and `err_cfg` is set; an accepted `start` clears it. K = `DEPTH` is accepted.
- R10: Table writes while the block is busy are ignored.
- R11: K and the iteration count are captured at `start`; changing `cfg_k` during a run has no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a decoding run when idle |
| cfg_k | input | KW | Block size K |
| cfg_iters | input | ITW | Number of full iterations |
| wr_empty | input | 1 | Downstream write path has drained |
| tbl_we | input | 1 | Table write strobe (idle only) |
| tbl_inv | input | 1 | 0 selects forward table, 1 inverse table |
| tbl_addr | input | AW | Table entry index |
| tbl_data | input | AW | Table entry value |
| busy | output | 1 | Run in progress |
| addr_valid | output | 1 | Address outputs are valid this cycle |
| half | output | 1 | 0 first half (interleave), 1 second half (deinterleave) |
| iter | output | ITW | Current iteration index |
| rd_mod | output | LANES·LOGP | Per-lane read module index |
| rd_off | output | LANES·OW | Per-lane read offset |
| wr_mod | output | LANES·LOGP | Per-lane write module index |
| wr_off | output | LANES·OW | Per-lane write offset |
| done | output | 1 | One-cycle pulse after the last iteration |
| err_cfg | output | 1 | Last start was rejected |
| err_rd | output | 1 | Read module collision seen in this run |

## Verification
The address outputs are compared every valid cycle against a bench-side model built from affine permutations with different multipliers and block sizes; a slice length of 3 gives collision-free reads, while slice lengths of 2 and 16 (including K equal to the table depth) force lanes onto the same module and must raise the read-collision flag. Runs with `wr_empty` held high and with a multi-cycle stall tell the drain wait apart from a fixed gap, and two-iteration runs separate the half and iteration sequencing. Rejected configurations, a mid-run change of K and a table write during a run each check that nothing leaks into the next run's addresses.

// File: rtl/turbo_sched_pkg.sv
package turbo_sched_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } sched_state_e;
endpackage

// File: rtl/sched_fsm.sv
module sched_fsm
   import turbo_sched_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 64,
   parameter int ITW   = 4,
   localparam int KW   = $clog2(DEPTH + 1),
   localparam int LOGP = $clog2(LANES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [KW-1:0]  cfg_k,
   input  logic [ITW-1:0] cfg_iters,
   input  logic           wr_empty,
   output logic           busy,
   output logic           run_valid,
   output logic           launch,
   output logic           half,
   output logic [ITW-1:0] iter,
   output logic [KW-1:0]  step,
   output logic [KW-1:0]  sub,
   output logic           done,
   output logic           err_cfg
);
   localparam logic [KW-1:0] KMAX  = KW'(DEPTH);
   localparam logic [KW-1:0] LMASK = KW'(LANES - 1);

   sched_state_e   state;
   logic [ITW-1:0] iters_q;
   logic           cfg_bad;

   // Launch-time screening of the requested configuration.
   assign cfg_bad = (cfg_k == '0) || (cfg_k > KMAX) ||
                    ((cfg_k & LMASK) != '0) || (cfg_iters == '0);
   assign launch    = (state == ST_IDLE) && start && !cfg_bad;
   assign busy      = (state != ST_IDLE);
   assign run_valid = (state == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         step    <= '0;
         sub     <= '0;
         iters_q <= '0;
         iter    <= '0;
         half    <= 1'b0;
         done    <= 1'b0;
         err_cfg <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (cfg_bad) begin
                     err_cfg <= 1'b1;
                  end else begin
                     err_cfg <= 1'b0;
                     sub     <= cfg_k >> LOGP;
                     iters_q <= cfg_iters;
                     iter    <= '0;
                     half    <= 1'b0;
                     step    <= '0;
                     state   <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (step == sub - 1'b1) begin
                  step  <= '0;
                  state <= ST_DRAIN;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (wr_empty) begin
                  if (!half) begin
                     half  <= 1'b1;
                     state <= ST_RUN;
                  end else if (iter == iters_q - 1'b1) begin
                     half  <= 1'b0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     half  <= 1'b0;
                     iter  <= iter + 1'b1;
                     state <= ST_RUN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_step_in_slice_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (step < sub));

   assert_drain_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && !wr_empty) |=> (state == ST_DRAIN));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_reject_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && cfg_bad) |=> (state == ST_IDLE && err_cfg));
endmodule

// File: rtl/sched_perm_tables.sv
module sched_perm_tables #(
   parameter int LANES = 4,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idle,
   input  logic                wr_en,
   input  logic                wr_inv,
   input  logic [AW-1:0]       wr_addr,
   input  logic [AW-1:0]       wr_data,
   input  logic                rd_inv,
   input  logic [LANES*AW-1:0] rd_pos,
   output logic [LANES*AW-1:0] rd_map
);
   logic [AW-1:0] fwd_q [DEPTH];
   logic [AW-1:0] inv_q [DEPTH];

   // Loading is only honoured between runs.
   always_ff @(posedge clk) begin
      if (idle && wr_en) begin
         if (wr_inv) inv_q[wr_addr] <= wr_data;
         else        fwd_q[wr_addr] <= wr_data;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_port
      assign rd_map[l*AW +: AW] = rd_inv ? inv_q[rd_pos[l*AW +: AW]]
                                         : fwd_q[rd_pos[l*AW +: AW]];
   end

   assert_busy_write_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && wr_en && !wr_inv) |=> (fwd_q[$past(wr_addr)] == $past(fwd_q[wr_addr])));

   assert_busy_write_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && wr_en && wr_inv) |=> (inv_q[$past(wr_addr)] == $past(inv_q[wr_addr])));
endmodule

// File: rtl/sched_lane_addr.sv
module sched_lane_addr #(
   parameter int LANE  = 0,
   parameter int LANES = 4,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int KW   = $clog2(DEPTH + 1),
   localparam int LOGP = $clog2(LANES),
   localparam int OW   = AW - LOGP
) (
   input  logic [KW-1:0]   step,
   input  logic [KW-1:0]   sub,
   input  logic [AW-1:0]   mapped,
   output logic [AW-1:0]   pos,
   output logic [LOGP-1:0] rd_mod,
   output logic [OW-1:0]   rd_off,
   output logic [LOGP-1:0] wr_mod,
   output logic [OW-1:0]   wr_off
);
   // Natural-order position inside this lane's slice.
   assign pos    = AW'(32'(LANE) * 32'(sub) + 32'(step));
   assign rd_mod = pos[LOGP-1:0];
   assign rd_off = pos[AW-1:LOGP];
   assign wr_mod = mapped[LOGP-1:0];
   assign wr_off = mapped[AW-1:LOGP];
endmodule

// File: rtl/turbo_half_sched.sv
module turbo_half_sched #(
   parameter int LANES = 4,
   parameter int DEPTH = 64,
   parameter int ITW   = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int KW   = $clog2(DEPTH + 1),
   localparam int LOGP = $clog2(LANES),
   localparam int OW   = AW - LOGP
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [KW-1:0]         cfg_k,
   input  logic [ITW-1:0]        cfg_iters,
   input  logic                  wr_empty,
   input  logic                  tbl_we,
   input  logic                  tbl_inv,
   input  logic [AW-1:0]         tbl_addr,
   input  logic [AW-1:0]         tbl_data,
   output logic                  busy,
   output logic                  addr_valid,
   output logic                  half,
   output logic [ITW-1:0]        iter,
   output logic [LANES*LOGP-1:0] rd_mod,
   output logic [LANES*OW-1:0]   rd_off,
   output logic [LANES*LOGP-1:0] wr_mod,
   output logic [LANES*OW-1:0]   wr_off,
   output logic                  done,
   output logic                  err_cfg,
   output logic                  err_rd
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (DEPTH < 2 * LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2*LANES");
   end

   logic                launch;
   logic [KW-1:0]       step;
   logic [KW-1:0]       sub;
   logic [LANES*AW-1:0] pos_bus;
   logic [LANES*AW-1:0] map_bus;
   logic                hit;

   sched_fsm #(.LANES(LANES), .DEPTH(DEPTH), .ITW(ITW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_k     (cfg_k),
      .cfg_iters (cfg_iters),
      .wr_empty  (wr_empty),
      .busy      (busy),
      .run_valid (addr_valid),
      .launch    (launch),
      .half      (half),
      .iter      (iter),
      .step      (step),
      .sub       (sub),
      .done      (done),
      .err_cfg   (err_cfg)
   );

   sched_perm_tables #(.LANES(LANES), .DEPTH(DEPTH)) u_tables (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle    (!busy),
      .wr_en   (tbl_we),
      .wr_inv  (tbl_inv),
      .wr_addr (tbl_addr),
      .wr_data (tbl_data),
      .rd_inv  (half),
      .rd_pos  (pos_bus),
      .rd_map  (map_bus)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sched_lane_addr #(.LANE(l), .LANES(LANES), .DEPTH(DEPTH)) u_lane (
         .step   (step),
         .sub    (sub),
         .mapped (map_bus[l*AW +: AW]),
         .pos    (pos_bus[l*AW +: AW]),
         .rd_mod (rd_mod[l*LOGP +: LOGP]),
         .rd_off (rd_off[l*OW +: OW]),
         .wr_mod (wr_mod[l*LOGP +: LOGP]),
         .wr_off (wr_off[l*OW +: OW])
      );
   end

   // Pairwise comparison of read module indices.
   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         for (int j = i + 1; j < LANES; j++) begin
            if (rd_mod[i*LOGP +: LOGP] == rd_mod[j*LOGP +: LOGP]) hit = 1'b1;
         end
      end
      hit = hit & addr_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_rd <= 1'b0;
      else if (launch) err_rd <= 1'b0;
      else if (hit)    err_rd <= 1'b1;
   end

   assert_collision_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !launch) |=> err_rd);

   assert_valid_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> busy);
endmodule

// File: tb/tb_turbo_half_sched.sv
module tb_turbo_half_sched;
   localparam int LANES = 4;
   localparam int DEPTH = 64;
   localparam int ITW   = 4;
   localparam int AW    = 6;
   localparam int KW    = 7;
   localparam int LOGP  = 2;
   localparam int OW    = 4;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [KW-1:0]         cfg_k = '0;
   logic [ITW-1:0]        cfg_iters = '0;
   logic                  wr_empty = 1'b1;
   logic                  tbl_we = 1'b0;
   logic                  tbl_inv = 1'b0;
   logic [AW-1:0]         tbl_addr = '0;
   logic [AW-1:0]         tbl_data = '0;
   logic                  busy, addr_valid, half, done, err_cfg, err_rd;
   logic [ITW-1:0]        iter;
   logic [LANES*LOGP-1:0] rd_mod, wr_mod;
   logic [LANES*OW-1:0]   rd_off, wr_off;

   int checks = 0;
   int failures = 0;
   int fwd_m [DEPTH];
   int inv_m [DEPTH];

   always #10 clk = ~clk;

   turbo_half_sched #(.LANES(LANES), .DEPTH(DEPTH), .ITW(ITW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_iters(cfg_iters),
      .wr_empty(wr_empty), .tbl_we(tbl_we), .tbl_inv(tbl_inv), .tbl_addr(tbl_addr),
      .tbl_data(tbl_data), .busy(busy), .addr_valid(addr_valid), .half(half),
      .iter(iter), .rd_mod(rd_mod), .rd_off(rd_off), .wr_mod(wr_mod), .wr_off(wr_off),
      .done(done), .err_cfg(err_cfg), .err_rd(err_rd)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic load_tables(input int k, input int a, input int b);
      for (int i = 0; i < k; i++) begin
         fwd_m[i] = (a * i + b) % k;
         inv_m[fwd_m[i]] = i;
      end
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < k; i++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_inv  = (t == 1);
            tbl_addr = AW'(i);
            tbl_data = AW'((t == 1) ? inv_m[i] : fwd_m[i]);
         end
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic check_lanes(input int sub, input int s, input int h, input int it);
      chk(addr_valid == 1'b1, "R2 valid", int'(addr_valid), 1);
      chk(int'(half) == h, "R4/R5 half", int'(half), h);
      chk(int'(iter) == it, "R7 iter", int'(iter), it);
      for (int p = 0; p < LANES; p++) begin
         int pos = p * sub + s;
         int m   = (h == 1) ? inv_m[pos] : fwd_m[pos];
         chk(int'(rd_mod[p*LOGP +: LOGP]) == pos % LANES, "R2/R3 rd_mod",
             int'(rd_mod[p*LOGP +: LOGP]), pos % LANES);
         chk(int'(rd_off[p*OW +: OW]) == pos / LANES, "R2/R3 rd_off",
             int'(rd_off[p*OW +: OW]), pos / LANES);
         chk(int'(wr_mod[p*LOGP +: LOGP]) == m % LANES,
             (h == 1) ? "R5 wr_mod" : "R4 wr_mod", int'(wr_mod[p*LOGP +: LOGP]), m % LANES);
         chk(int'(wr_off[p*OW +: OW]) == m / LANES,
             (h == 1) ? "R5 wr_off" : "R4 wr_off", int'(wr_off[p*OW +: OW]), m / LANES);
      end
   endtask

   task automatic run_case(input int k, input int iters, input int stall,
                           input bit expect_collide, input bit change_k);
      int sub = k / LANES;
      int nd  = (stall == 0) ? 1 : stall;
      @(negedge clk);
      cfg_k     = KW'(k);
      cfg_iters = ITW'(iters);
      wr_empty  = (stall == 0);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err_cfg == 1'b0, "R9 accepted start clears err_cfg", int'(err_cfg), 0);
      if (change_k) cfg_k = KW'(20); // R11: must not disturb the run
      for (int it = 0; it < iters; it++) begin
         for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < sub; s++) begin
               check_lanes(sub, s, h, it);
               @(negedge clk);
            end
            for (int d = 0; d < nd; d++) begin
               chk(addr_valid == 1'b0, "R6 valid low in drain", int'(addr_valid), 0);
               chk(busy == 1'b1, "R6 busy in drain", int'(busy), 1);
               if (d == nd - 1) wr_empty = 1'b1;
               @(negedge clk);
            end
            wr_empty = (stall == 0);
         end
      end
      chk(done == 1'b1, "R7 done pulse", int'(done), 1);
      chk(busy == 1'b0, "R7 idle after last iteration", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      chk(err_rd == expect_collide, "R8 read collision flag", int'(err_rd), int'(expect_collide));
      wr_empty = 1'b1;
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(addr_valid == 1'b0, "R1 valid", int'(addr_valid), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(err_cfg == 1'b0, "R1 err_cfg", int'(err_cfg), 0);
      chk(err_rd == 1'b0, "R1 err_rd", int'(err_rd), 0);
   endtask

   task automatic try_bad(input int k, input int iters);
      @(negedge clk);
      cfg_k     = KW'(k);
      cfg_iters = ITW'(iters);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err_cfg == 1'b1, "R9 reject flag", int'(err_cfg), 1);
      chk(busy == 1'b0, "R9 stays idle", int'(busy), 0);
      chk(addr_valid == 1'b0, "R9 no addresses", int'(addr_valid), 0);
   endtask

   task automatic t_bad_cfg;
      try_bad(0, 2);
      try_bad(68, 2);
      try_bad(6, 2);
      try_bad(8, 0);
   endtask

   task automatic t_collide;
      load_tables(8, 3, 2);
      run_case(8, 1, 0, 1'b1, 1'b0);
   endtask

   task automatic t_full_depth;
      load_tables(64, 7, 5);
      run_case(64, 1, 0, 1'b1, 1'b0);
   endtask

   task automatic t_main;
      load_tables(12, 5, 1);
      run_case(12, 2, 0, 1'b0, 1'b0);
   endtask

   task automatic t_stall;
      run_case(12, 2, 3, 1'b0, 1'b0);
   endtask

   task automatic t_k_latched;
      run_case(12, 1, 0, 1'b0, 1'b1);
   endtask

   task automatic t_busy_write;
      int guard = 0;
      @(negedge clk);
      cfg_k     = KW'(12);
      cfg_iters = ITW'(1);
      wr_empty  = 1'b1;
      start     = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      tbl_we   = 1'b1;   // R10: forward entry 0 would become 11
      tbl_inv  = 1'b0;
      tbl_addr = '0;
      tbl_data = AW'(11);
      @(negedge clk);
      tbl_inv  = 1'b1;   // R10: inverse entry 1 would become 9
      tbl_addr = AW'(1);
      tbl_data = AW'(9);
      @(negedge clk);
      tbl_we = 1'b0;
      while (!done && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      run_case(12, 1, 0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main_seq
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_cfg();
      t_collide();
      t_full_depth();
      t_main();
      t_stall();
      t_k_latched();
      t_busy_write();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule